// File: doc/BRIEF.md
# Sector Buffered Flash Program Engine

This block is the device-side controller of a word-wide nonvolatile array that is rewritten one whole sector at a time. A host drives an active-low select, an active-low read enable and an active-low write strobe. Each falling edge of the strobe latches the word offset and data into a page buffer. The offsets may arrive in any order, and all of them must fall in the sector of the first word of the phase. When the strobe has stayed released for a programmable window without a new falling edge, the loading phase closes. The engine then erases the sector and programs it from the page buffer, using internal timers. The array itself is a register model with a small number of sectors.

While the engine is busy, reads return a status word instead of array data. Bits 15 and 7 carry the inverse of the last accepted word's bits 15 and 7. Bits 14 and 6 carry a flag that changes on every read. Polling either pair tells software when the array is free again. All intervals are given in microseconds and turned into clock cycles through a clock-frequency parameter. A testbench can shorten them by setting a small frequency.

Top module: `sector_prog_engine`

## Requirements
- R1: After reset, busy_o and sect_err_o are 0, rdata_o is 0, and every array word reads 16'hFFFF.
- R2: A read access is the first cycle in which select_ni=0, rd_en_ni=0 and wr_stb_ni=1 hold together. When the engine is not busy, rdata_o holds the array word at addr_i from the cycle after the access, and it keeps that value until the next access.
- R3: A load is the first cycle in which wr_stb_ni=0, while select_ni=0 and rd_en_ni=1. It latches wdata_i at offset addr_i[6:0] of the sector addr_i[ADDR_W-1:7]. Offsets may arrive in any order.
- R4: A falling strobe while rd_en_ni=0 or select_ni=1 loads nothing and starts no phase.
- R5: The loading phase ends after TMO cycles in a row with the strobe high. A falling strobe after TMO-1 high cycles still counts as part of the phase. busy_o rises in the cycle after the TMO-th high cycle.
- R6: busy_o stays high for exactly ERASE+PROG cycles.
- R7: When busy_o falls, the words loaded in the phase hold their data, the other words of that sector read 16'hFFFF, and all other sectors are unchanged.
- R8: A read access during busy returns bit15 = ~last[15] and bit7 = ~last[7], where last is the last word accepted in the phase. Bits 13:8 and 5:0 read 0.
- R9: In a busy status word, bits 14 and 6 are equal. They read 0 on the first busy read of a program cycle and invert on each later busy read.
- R10: A load attempted while busy changes nothing and starts no new phase.
- R11: A load whose sector differs from the sector of the phase's first word is dropped and sets sect_err_o. sect_err_o stays set until reset.
- R12: When an offset is loaded more than once in a phase, the last data written to it is programmed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| select_ni | input | 1 | Block select, active low |
| rd_en_ni | input | 1 | Read enable, active low; must be high for loads |
| wr_stb_ni | input | 1 | Load strobe, active low |
| addr_i | input | ADDR_W | Sector (upper bits) and word offset (low 7 bits) |
| wdata_i | input | 16 | Load data |
| rdata_o | output | 16 | Registered read data or busy status word |
| busy_o | output | 1 | High during erase and program |
| sect_err_o | output | 1 | Sticky flag for a load to the wrong sector |

## Verification
Read data appears one cycle after the access cycle. The bench samples it on the falling edge that follows that single rising edge. busy_o rises on the TMO-th rising edge after the last strobe release, and the bench checks it at the falling edges just before and just after that edge. The fall of busy_o is checked in the same way, ERASE+PROG edges later. A sector error shows at the falling edge right after the rejected load. Array contents are checked only once busy_o has dropped, by sweeping all addresses against a model kept in the bench.

// File: rtl/spe_pkg.sv
`timescale 1ns/1ps
package spe_pkg;
  localparam int WORD_W = 16;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LOAD  = 2'd1,
    ST_ERASE = 2'd2,
    ST_PROG  = 2'd3
  } spe_state_e;
endpackage

// File: rtl/spe_gap_timer.sv
`timescale 1ns/1ps
module spe_gap_timer #(
  parameter int TMO_CYC = 150
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic clear_i,
  output logic expire_o
);
  localparam int TW = $clog2(TMO_CYC + 1);
  logic [TW-1:0] cnt_q;

  assign expire_o = run_i && !clear_i && (cnt_q == TW'(TMO_CYC - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (clear_i || !run_i)  cnt_q <= '0;
    else if (!expire_o)          cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/spe_page_buf.sv
`timescale 1ns/1ps
module spe_page_buf import spe_pkg::*; #(
  parameter int WORDS = 128,
  parameter int OFS_W = $clog2(WORDS)
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          clr_i,
  input  logic                          wr_i,
  input  logic [OFS_W-1:0]              ofs_i,
  input  logic [WORD_W-1:0]             data_i,
  output logic [WORDS-1:0][WORD_W-1:0]  data_o,
  output logic [WORDS-1:0]              valid_o
);
  for (genvar w = 0; w < WORDS; w++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        data_o[w]  <= '0;
        valid_o[w] <= 1'b0;
      end else if (wr_i && ofs_i == OFS_W'(w)) begin
        data_o[w]  <= data_i;
        valid_o[w] <= 1'b1;
      end else if (clr_i) begin
        valid_o[w] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/spe_sector_array.sv
`timescale 1ns/1ps
module spe_sector_array import spe_pkg::*; #(
  parameter int NUM_SECT = 4,
  parameter int WORDS    = 128,
  parameter int SECT_W   = $clog2(NUM_SECT),
  parameter int ADDR_W   = $clog2(NUM_SECT * WORDS)
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          erase_i,
  input  logic                          commit_i,
  input  logic [SECT_W-1:0]             sect_i,
  input  logic [WORDS-1:0][WORD_W-1:0]  buf_data_i,
  input  logic [WORDS-1:0]              valid_i,
  input  logic [ADDR_W-1:0]             rd_addr_i,
  output logic [WORD_W-1:0]             rd_data_o
);
  localparam int DEPTH = NUM_SECT * WORDS;
  logic [WORD_W-1:0] mem_q [DEPTH];

  for (genvar s = 0; s < NUM_SECT; s++) begin : g_sect
    for (genvar w = 0; w < WORDS; w++) begin : g_word
      localparam int IDX = s * WORDS + w;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)
          mem_q[IDX] <= '1;
        else if (erase_i && sect_i == SECT_W'(s))
          mem_q[IDX] <= '1;
        else if (commit_i && sect_i == SECT_W'(s) && valid_i[w])
          mem_q[IDX] <= buf_data_i[w];
      end
    end
  end

  assign rd_data_o = mem_q[rd_addr_i];
endmodule

// File: rtl/spe_status.sv
`timescale 1ns/1ps
module spe_status import spe_pkg::*; (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              arm_i,
  input  logic              busy_i,
  input  logic              acc_i,
  input  logic [WORD_W-1:0] last_i,
  input  logic [WORD_W-1:0] arr_i,
  output logic [WORD_W-1:0] rdata_o
);
  logic tog_q;
  logic [WORD_W-1:0] stat_w;

  // polling pair in 15/7, toggle pair in 14/6
  always_comb begin
    stat_w     = '0;
    stat_w[15] = ~last_i[15];
    stat_w[14] = tog_q;
    stat_w[7]  = ~last_i[7];
    stat_w[6]  = tog_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               tog_q <= 1'b0;
    else if (arm_i)            tog_q <= 1'b0;
    else if (acc_i && busy_i)  tog_q <= ~tog_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     rdata_o <= '0;
    else if (acc_i)  rdata_o <= busy_i ? stat_w : arr_i;
  end
endmodule

// File: rtl/sector_prog_engine.sv
`timescale 1ns/1ps
module sector_prog_engine import spe_pkg::*; #(
  parameter int NUM_SECT = 4,
  parameter int WORDS    = 128,
  parameter int ADDR_W   = $clog2(NUM_SECT * WORDS),
  parameter int CLK_HZ   = 100_000_000,
  parameter int TMO_US   = 150,
  parameter int ERASE_US = 4000,
  parameter int PROG_US  = 6000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              select_ni,
  input  logic              rd_en_ni,
  input  logic              wr_stb_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [15:0]       wdata_i,
  output logic [15:0]       rdata_o,
  output logic              busy_o,
  output logic              sect_err_o
);
  localparam int OFS_W      = $clog2(WORDS);
  localparam int SECT_W     = ADDR_W - OFS_W;
  localparam int CYC_PER_US = CLK_HZ / 1_000_000;
  localparam int TMO_CYC    = TMO_US * CYC_PER_US;
  localparam int ERASE_CYC  = ERASE_US * CYC_PER_US;
  localparam int PROG_CYC   = PROG_US * CYC_PER_US;
  localparam int MAX_PH     = (ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC;
  localparam int CNT_W      = $clog2(MAX_PH + 1);

  spe_state_e         state_q;
  logic [CNT_W-1:0]   ph_cnt_q;
  logic [SECT_W-1:0]  sect_q;
  logic [WORD_W-1:0]  last_q;
  logic               err_q, stb_q, rd_q;

  logic [SECT_W-1:0]  in_sect;
  logic [OFS_W-1:0]   in_ofs;
  logic rd_cond, rd_acc, ld_try, accepting, sect_ok, ld_ok, expire;
  logic erase_go, commit_go, ph_last;
  logic [WORDS-1:0][WORD_W-1:0] buf_data;
  logic [WORDS-1:0]             buf_valid;
  logic [WORD_W-1:0]            arr_rd;

  assign in_sect   = addr_i[ADDR_W-1:OFS_W];
  assign in_ofs    = addr_i[OFS_W-1:0];
  assign rd_cond   = !select_ni && !rd_en_ni && wr_stb_ni;
  assign rd_acc    = rd_cond && !rd_q;
  assign ld_try    = !select_ni && rd_en_ni && !wr_stb_ni && stb_q;
  assign accepting = (state_q == ST_IDLE) || (state_q == ST_LOAD);
  assign sect_ok   = (state_q != ST_LOAD) || (in_sect == sect_q);
  assign ld_ok     = ld_try && accepting && sect_ok;
  assign busy_o    = (state_q == ST_ERASE) || (state_q == ST_PROG);
  assign sect_err_o = err_q;

  assign ph_last   = (state_q == ST_ERASE) ? (ph_cnt_q == CNT_W'(ERASE_CYC - 1))
                                           : (ph_cnt_q == CNT_W'(PROG_CYC - 1));
  assign erase_go  = (state_q == ST_ERASE) && (ph_cnt_q == '0);
  assign commit_go = (state_q == ST_PROG) && ph_last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stb_q <= 1'b1;
      rd_q  <= 1'b0;
    end else begin
      stb_q <= wr_stb_ni;
      rd_q  <= rd_cond;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      ph_cnt_q <= '0;
      sect_q   <= '0;
      last_q   <= '0;
      err_q    <= 1'b0;
    end else begin
      if (ld_ok) last_q <= wdata_i;
      if (ld_try && state_q == ST_LOAD && !sect_ok) err_q <= 1'b1;
      unique case (state_q)
        ST_IDLE: if (ld_ok) begin
          state_q <= ST_LOAD;
          sect_q  <= in_sect;
        end
        ST_LOAD: if (expire) begin
          state_q  <= ST_ERASE;
          ph_cnt_q <= '0;
        end
        ST_ERASE: begin
          if (ph_last) begin
            state_q  <= ST_PROG;
            ph_cnt_q <= '0;
          end else begin
            ph_cnt_q <= ph_cnt_q + 1'b1;
          end
        end
        ST_PROG: begin
          if (ph_last) begin
            state_q  <= ST_IDLE;
            ph_cnt_q <= '0;
          end else begin
            ph_cnt_q <= ph_cnt_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  spe_gap_timer #(.TMO_CYC(TMO_CYC)) u_gap (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (state_q == ST_LOAD),
    .clear_i  (!wr_stb_ni),
    .expire_o (expire)
  );

  spe_page_buf #(.WORDS(WORDS), .OFS_W(OFS_W)) u_buf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (state_q == ST_IDLE),
    .wr_i    (ld_ok),
    .ofs_i   (in_ofs),
    .data_i  (wdata_i),
    .data_o  (buf_data),
    .valid_o (buf_valid)
  );

  spe_sector_array #(
    .NUM_SECT(NUM_SECT), .WORDS(WORDS), .SECT_W(SECT_W), .ADDR_W(ADDR_W)
  ) u_arr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .erase_i    (erase_go),
    .commit_i   (commit_go),
    .sect_i     (sect_q),
    .buf_data_i (buf_data),
    .valid_i    (buf_valid),
    .rd_addr_i  (addr_i),
    .rd_data_o  (arr_rd)
  );

  spe_status u_stat (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .arm_i   (expire),
    .busy_i  (busy_o),
    .acc_i   (rd_acc),
    .last_i  (last_q),
    .arr_i   (arr_rd),
    .rdata_o (rdata_o)
  );
endmodule

// File: rtl/spe_checker.sv
`timescale 1ns/1ps
module spe_checker #(
  parameter int BUSY_CYC = 10
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        select_ni,
  input logic        rd_en_ni,
  input logic        wr_stb_ni,
  input logic [15:0] rdata_o,
  input logic        busy_o,
  input logic        sect_err_o
);
  localparam int BW = $clog2(BUSY_CYC + 2);
  logic rd_cq, pend_q, tog_seen_q, prev_tog_q;
  logic [BW-1:0] bcnt_q;
  logic rd_acc;

  assign rd_acc = !select_ni && !rd_en_ni && wr_stb_ni && !rd_cq;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_cq <= 1'b0; pend_q <= 1'b0; tog_seen_q <= 1'b0;
      prev_tog_q <= 1'b0; bcnt_q <= '0;
    end else begin
      rd_cq  <= !select_ni && !rd_en_ni && wr_stb_ni;
      pend_q <= rd_acc && busy_o;
      if (!busy_o) tog_seen_q <= 1'b0;
      else if (pend_q) begin
        tog_seen_q <= 1'b1;
        prev_tog_q <= rdata_o[6];
      end
      if (!busy_o)                         bcnt_q <= '0;
      else if (bcnt_q != BW'(BUSY_CYC + 1)) bcnt_q <= bcnt_q + 1'b1;
    end
  end

  assert_status_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_acc && busy_o) |=> (rdata_o[13:8] == 6'd0 && rdata_o[5:0] == 6'd0));

  assert_toggle_pair_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_acc && busy_o) |=> (rdata_o[14] == rdata_o[6]));

  assert_toggle_flip_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && tog_seen_q) |-> (rdata_o[6] != prev_tog_q));

  assert_err_sticky_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sect_err_o |=> sect_err_o);

  assert_busy_len_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> (bcnt_q == BW'(BUSY_CYC)));

  assert_busy_bound_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (bcnt_q < BW'(BUSY_CYC)));
endmodule

bind sector_prog_engine spe_checker #(.BUSY_CYC(ERASE_CYC + PROG_CYC)) u_spe_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .select_ni  (select_ni),
  .rd_en_ni   (rd_en_ni),
  .wr_stb_ni  (wr_stb_ni),
  .rdata_o    (rdata_o),
  .busy_o     (busy_o),
  .sect_err_o (sect_err_o)
);

// File: tb/sector_prog_engine_tb.sv
`timescale 1ns/1ps
module sector_prog_engine_tb;
  localparam int NS   = 4;
  localparam int WD   = 128;
  localparam int AW   = 9;
  localparam int TMO  = 8;
  localparam int BUSY = 50;   // 20 erase + 30 program

  logic clk = 1'b0, rst_n = 1'b0;
  logic sel_n = 1'b1, rd_n = 1'b1, stb_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic busy, serr;

  int total = 0, bad = 0;
  logic [15:0] model [NS*WD];
  logic        pv [WD];
  logic [15:0] pd [WD];
  int          psect;

  always #2.5 clk = ~clk;

  sector_prog_engine #(
    .NUM_SECT(NS), .WORDS(WD), .ADDR_W(AW), .CLK_HZ(1_000_000),
    .TMO_US(TMO), .ERASE_US(20), .PROG_US(30)
  ) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .select_ni(sel_n), .rd_en_ni(rd_n),
    .wr_stb_ni(stb_n), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .busy_o(busy), .sect_err_o(serr)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=done");
    finish_run();
  end

  task automatic do_read(input int a, output logic [15:0] v);
    addr = AW'(a); sel_n = 1'b0; rd_n = 1'b0; stb_n = 1'b1;
    @(posedge clk); @(negedge clk);
    v = rdata; rd_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic do_load(input int a, input logic [15:0] d, input int gap);
    addr = AW'(a); wdata = d; rd_n = 1'b1; stb_n = 1'b0;
    @(posedge clk); @(negedge clk);
    stb_n = 1'b1;
    repeat (gap) @(negedge clk);
  endtask

  task automatic phase_open(input int s);
    psect = s;
    for (int w = 0; w < WD; w++) pv[w] = 1'b0;
  endtask

  task automatic note(input int off, input logic [15:0] d);
    pv[off] = 1'b1; pd[off] = d;
  endtask

  task automatic commit_model();
    for (int w = 0; w < WD; w++) model[psect*WD+w] = pv[w] ? pd[w] : 16'hFFFF;
  endtask

  task automatic sweep(input string req);
    logic [15:0] v;
    for (int a = 0; a < NS*WD; a++) begin
      do_read(a, v);
      chk(req, v, model[a]);
    end
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  initial begin
    logic [15:0] v, held;
    bit seen;
    for (int a = 0; a < NS*WD; a++) model[a] = 16'hFFFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 busy", {15'd0, busy}, 16'd0);
    chk("R1 err", {15'd0, serr}, 16'd0);
    chk("R1 rdata", rdata, 16'd0);
    sel_n = 1'b0;
    sweep("R1/R2 erased array");

    // R2 hold between accesses
    do_read(3, v);
    held = rdata;
    repeat (5) @(negedge clk);
    chk("R2 hold", rdata, held);

    // R4 gated loads
    sel_n = 1'b1;
    do_load(7, 16'h1111, 2);
    sel_n = 1'b0; rd_n = 1'b0; addr = 9'd8; wdata = 16'h2222; stb_n = 1'b0;
    @(posedge clk); @(negedge clk);
    stb_n = 1'b1; rd_n = 1'b1;
    seen = 1'b0;
    for (int i = 0; i < 2*TMO + BUSY; i++) begin
      @(negedge clk);
      if (busy) seen = 1'b1;
    end
    chk("R4 no phase", {15'd0, seen}, 16'd0);
    do_read(7, v); chk("R4 word7", v, 16'hFFFF);
    do_read(8, v); chk("R4 word8", v, 16'hFFFF);

    // Phase A: sector 1, even offsets in reverse order (R3 R5 R6 R7 R12)
    phase_open(1);
    for (int o = WD - 2; o >= 0; o -= 2) begin
      logic [15:0] d;
      d = 16'(o * 16'h0203) ^ 16'hA5C3;
      do_load(WD + o, d, (o == 64) ? TMO - 1 : 1);
      note(o, d);
    end
    do_load(WD + 10, 16'hBEEF, 1); note(10, 16'hBEEF);   // R12
    do_load(WD + 1, 16'h0F0F, 0);  note(1, 16'h0F0F);
    repeat (TMO - 1) @(negedge clk);
    chk("R5 busy before timeout", {15'd0, busy}, 16'd0);
    @(negedge clk);
    chk("R5 busy after timeout", {15'd0, busy}, 16'd1);
    repeat (BUSY - 1) @(negedge clk);
    chk("R6 busy last cycle", {15'd0, busy}, 16'd1);
    @(negedge clk);
    chk("R6 busy dropped", {15'd0, busy}, 16'd0);
    commit_model();
    sweep("R7/R3/R12 after program");

    // Phase B: sector 2, status reads and busy loads (R8 R9 R10)
    phase_open(2);
    do_load(2*WD + 5, 16'h7E7E, 1); note(5, 16'h7E7E);
    do_load(2*WD + 3, 16'h8001, 0); note(3, 16'h8001);
    while (!busy) @(negedge clk);
    for (int k = 0; k < 4; k++) begin
      logic [15:0] e;
      e = 16'h0080;                       // ~bit15=0, ~bit7=1
      if (k % 2 == 1) e = e | 16'h4040;
      do_read(0, v);
      chk("R8/R9 status word", v, e);
    end
    do_load(2*WD + 100, 16'h0000, 1);     // R10
    chk("R10 still busy", {15'd0, busy}, 16'd1);
    wait_idle();
    seen = 1'b0;
    for (int i = 0; i < TMO + 5; i++) begin
      @(negedge clk);
      if (busy) seen = 1'b1;
    end
    chk("R10 no new phase", {15'd0, seen}, 16'd0);
    commit_model();
    do_read(2*WD + 100, v); chk("R10 word untouched", v, 16'hFFFF);
    sweep("R7 sector2 and others");

    // Phase C: wrong-sector load (R11)
    phase_open(3);
    do_load(3*WD + 0, 16'h1357, 1); note(0, 16'h1357);
    chk("R11 err clear", {15'd0, serr}, 16'd0);
    do_load(0*WD + 5, 16'h2468, 1);
    chk("R11 err set", {15'd0, serr}, 16'd1);
    do_load(3*WD + 1, 16'h9ABC, 0); note(1, 16'h9ABC);
    while (!busy) @(negedge clk);
    wait_idle();
    commit_model();
    chk("R11 err sticky", {15'd0, serr}, 16'd1);
    do_read(5, v); chk("R11 dropped word", v, model[5]);
    sweep("R11/R7 sector3");

    // reset again
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 err after reset", {15'd0, serr}, 16'd0);
    chk("R1 busy after reset", {15'd0, busy}, 16'd0);
    do_read(3*WD + 0, v); chk("R1 array reset", v, 16'hFFFF);
    finish_run();
  end
endmodule